// File: doc/BRIEF.md
# Dual Wiper Serial Control Interface

This block is a write-only, three-wire serial slave that sets two independent 8-bit wiper position codes. An external host pulls an active-low select line low and shifts a ten-bit command, MSB first, on the rising edges of a serial clock. When the select line returns high, the block takes the ten most recent bits. It decodes a two-bit address and writes the eight data bits into wiper register 0, wiper register 1, or both. There is no separate update command: the new code appears on the wiper output as soon as the frame is accepted. For each register, a one-cycle strobe marks the system-clock cycle in which that register takes new data.

All three serial lines pass through multi-flop synchronizers into the system clock domain. Edges of the serial clock and the select line are found from the synchronized samples. For this reason the system clock must run at least four times faster than the serial clock. After reset, both wipers sit at midscale.

Top module: `dual_wiper_ser_ctrl`

## Requirements
- R1: Serial data is shifted in only on rising edges of the serial clock seen while the select line is low. Serial clock edges while the select line is high change no wiper and raise no strobe.
- R2: When the select line rises after more than ten clock edges, the block commits only the last ten bits shifted in.
- R3: Bit order within the ten-bit command: the first bit sent is address bit 1, the second is address bit 0, and data bits 7 down to 0 follow.
- R4: Address 00 writes the data to wiper 0. Address 01 writes the data to wiper 1.
- R5: Address 11 writes the same data to both wipers in the same cycle. Both strobes rise together.
- R6: After the asynchronous reset, both wipers hold 0x80 and both strobes are low.
- R7: A write addressed to one wiper leaves the other wiper's code unchanged.
- R8: A frame with address 10 changes neither wiper and raises no strobe.
- R9: A frame in which fewer than ten serial clock edges arrived while the select line was low is discarded. Neither wiper changes.
- R10: Each update strobe is high for exactly one system clock cycle. That is the cycle in which its wiper first shows the new code.
- R11: A falling edge of the select line clears the bit count and the shift register. A short frame that follows a complete frame is therefore still discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data in |
| wiper0_o | output | 8 | Wiper 0 position code |
| wiper1_o | output | 8 | Wiper 1 position code |
| upd0_o | output | 1 | Wiper 0 update strobe |
| upd1_o | output | 1 | Wiper 1 update strobe |

## Verification
The hardest case to reach is the stale-state hazard of R11. The bit counter saturates, so a short frame is only rejected if the count was really cleared on the preceding select fall. The stimulus therefore sends a fourteen-bit frame and then, straight after it, a seven-bit frame whose trailing bits would form a valid command. A missing clear would commit that command. Serial clock bursts with the select line high are also driven between frames, to show that idle-time toggling leaves no trace in the next frame.

// File: rtl/dws_pkg.sv
package dws_pkg;

   // Two-bit address carried in the top of every command word
   typedef enum logic [1:0] {
      ADR_CH0  = 2'b00,
      ADR_CH1  = 2'b01,
      ADR_RSVD = 2'b10,
      ADR_ALL  = 2'b11
   } dws_addr_e;

   localparam int DWS_ADDR_W = 2;

   // True when the address selects channel ch
   function automatic logic dws_chan_hit(input logic [1:0] adr, input int ch);
      logic hit;
      case (dws_addr_e'(adr))
         ADR_CH0:  hit = (ch == 0);
         ADR_CH1:  hit = (ch == 1);
         ADR_ALL:  hit = 1'b1;
         default:  hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/dws_sync.sv
module dws_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dws_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("dws_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dws_frame_rx.sv
module dws_frame_rx #(
   parameter int FRAME_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_n_s,
   input  logic               sclk_s,
   input  logic               dat_s,
   output logic               commit_o,
   output logic [FRAME_W-1:0] word_o
);

   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("dws_frame_rx: FRAME_W must be at least 2");
      end
   endgenerate

   logic             sel_q, sclk_q;
   logic             sel_fall, sel_rise, sclk_rise;
   logic [CNT_W-1:0] cnt_q;
   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         sel_q  <= sel_n_s;
         sclk_q <= sclk_s;
      end
   end

   assign sel_fall  = sel_q & ~sel_n_s;
   assign sel_rise  = ~sel_q & sel_n_s;
   assign sclk_rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (sel_fall) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (!sel_n_s && sclk_rise) begin
         sh_q <= {sh_q[FRAME_W-2:0], dat_s};
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign commit_o = sel_rise && (cnt_q == CNT_FULL);
   assign word_o   = sh_q;

   // R11: a select fall leaves a clean frame state
   a_r11_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> (cnt_q == '0 && sh_q == '0));

   // R1: no shifting while select stays high
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && sel_n_s) |=> $stable(sh_q));

   // R9: count never passes the frame length
   a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

endmodule

// File: rtl/dws_wiper_bank.sv
module dws_wiper_bank
   import dws_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                NCH      = 2,
   parameter logic [DATA_W-1:0] RST_CODE = DATA_W'(1) << (DATA_W - 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit_i,
   input  logic [DWS_ADDR_W+DATA_W-1:0]  word_i,
   output logic [NCH-1:0][DATA_W-1:0]    wiper_o,
   output logic [NCH-1:0]                upd_o
);

   generate
      if (NCH != 2) begin : g_bad_nch
         $error("dws_wiper_bank: address decode supports exactly two channels");
      end
   endgenerate

   logic [DWS_ADDR_W-1:0] adr;
   logic [DATA_W-1:0]     dat;

   assign adr = word_i[DWS_ADDR_W+DATA_W-1:DATA_W];
   assign dat = word_i[DATA_W-1:0];

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         logic hit;
         assign hit = commit_i && dws_chan_hit(adr, ch);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wiper_o[ch] <= RST_CODE;
               upd_o[ch]   <= 1'b0;
            end else begin
               upd_o[ch] <= hit;
               if (hit) wiper_o[ch] <= dat;
            end
         end

         // R10: strobe lasts one cycle
         a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
            upd_o[ch] |=> !upd_o[ch]);

         // R7: a wiper moves only after a commit
         a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_i |=> $stable(wiper_o[ch]));

         // R8: reserved address touches nothing
         a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_i && adr == ADR_RSVD) |=> (!upd_o[ch] && $stable(wiper_o[ch])));
      end
   endgenerate

   // R5: broadcast raises both strobes together
   a_r5_broadcast_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && adr == ADR_ALL) |=> (upd_o[0] && upd_o[1] && wiper_o[0] == wiper_o[1]));

endmodule

// File: rtl/dual_wiper_ser_ctrl.sv
module dual_wiper_ser_ctrl
   import dws_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   output logic [DATA_W-1:0] wiper0_o,
   output logic [DATA_W-1:0] wiper1_o,
   output logic              upd0_o,
   output logic              upd1_o
);

   localparam int FRAME_W = DWS_ADDR_W + DATA_W;
   localparam int NCH     = 2;
   localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("dual_wiper_ser_ctrl: DATA_W must be at least 2");
      end
   endgenerate

   logic [2:0] raw_in, sync_out;
   logic       commit;
   logic [FRAME_W-1:0]        word;
   logic [NCH-1:0][DATA_W-1:0] wipers;
   logic [NCH-1:0]             upds;

   assign raw_in = {ser_dat, ser_clk, ser_sel_n};

   dws_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_out)
   );

   dws_frame_rx #(
      .FRAME_W (FRAME_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n_s  (sync_out[0]),
      .sclk_s   (sync_out[1]),
      .dat_s    (sync_out[2]),
      .commit_o (commit),
      .word_o   (word)
   );

   dws_wiper_bank #(
      .DATA_W   (DATA_W),
      .NCH      (NCH),
      .RST_CODE (MID_CODE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .word_i   (word),
      .wiper_o  (wipers),
      .upd_o    (upds)
   );

   assign wiper0_o = wipers[0];
   assign wiper1_o = wipers[1];
   assign upd0_o   = upds[0];
   assign upd1_o   = upds[1];

endmodule

// File: tb/tb_dual_wiper_ser_ctrl.sv
module tb_dual_wiper_ser_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCLK  = 4;   // system cycles per serial half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_sel_n = 1'b1;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic [7:0] wiper0_o, wiper1_o;
   logic       upd0_o, upd1_o;

   dual_wiper_ser_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_sel_n (ser_sel_n),
      .ser_clk   (ser_clk),
      .ser_dat   (ser_dat),
      .wiper0_o  (wiper0_o),
      .wiper1_o  (wiper1_o),
      .upd0_o    (upd0_o),
      .upd1_o    (upd1_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic [7:0] w0;
      logic [7:0] w1;
      logic       u0;
      logic       u1;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   logic [7:0] m_w0 = 8'h80;
   logic [7:0] m_w1 = 8'h80;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Driver: shifts n bits, MSB first from bits[n-1], and predicts the result
   task automatic send_frame(input int n, input logic [15:0] bits, input string req);
      logic [9:0] w;
      exp_t e;
      @(negedge clk);
      ser_sel_n = 1'b0;
      repeat (HALF_SCLK) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = bits[i];
         repeat (HALF_SCLK) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF_SCLK) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (HALF_SCLK) @(negedge clk);
      w = bits[9:0];
      if (n >= 10 && w[9:8] != 2'b10) begin
         e.u0 = (w[9:8] == 2'b00) || (w[9:8] == 2'b11);
         e.u1 = (w[9:8] == 2'b01) || (w[9:8] == 2'b11);
         if (e.u0) m_w0 = w[7:0];
         if (e.u1) m_w1 = w[7:0];
         e.w0 = m_w0;
         e.w1 = m_w1;
         exp_q.push_back(e);
      end
      ser_sel_n = 1'b1;
      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, req, "pending update never seen", exp_q.size(), 0);
      chk(wiper0_o == m_w0, req, "wiper0 after frame", wiper0_o, m_w0);
      chk(wiper1_o == m_w1, req, "wiper1 after frame", wiper1_o, m_w1);
   endtask

   // Monitor: pops one expected item per strobe event and checks strobe width
   logic prev_u0 = 1'b0, prev_u1 = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (upd0_o || upd1_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8/R9", "unexpected strobe", {upd1_o, upd0_o}, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk({upd1_o, upd0_o} == {e.u1, e.u0}, "R4/R5/R7", "strobe pattern",
                   {upd1_o, upd0_o}, {e.u1, e.u0});
               chk(wiper0_o == e.w0, "R10", "wiper0 at strobe", wiper0_o, e.w0);
               chk(wiper1_o == e.w1, "R10", "wiper1 at strobe", wiper1_o, e.w1);
            end
         end
         if ((prev_u0 && upd0_o) || (prev_u1 && upd1_o))
            chk(1'b0, "R10", "strobe longer than one cycle", 2, 1);
         prev_u0 = upd0_o;
         prev_u1 = upd1_o;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(wiper0_o == 8'h80, "R6", "wiper0 in reset", wiper0_o, 8'h80);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(wiper0_o == 8'h80, "R6", "wiper0 after reset", wiper0_o, 8'h80);
      chk(wiper1_o == 8'h80, "R6", "wiper1 after reset", wiper1_o, 8'h80);
      chk(!upd0_o && !upd1_o, "R6", "strobes after reset", {upd1_o, upd0_o}, 0);

      // R3 R4: ch0 then ch1, asymmetric data exposes bit order
      send_frame(10, 16'b00_1100_1010, "R3");
      send_frame(10, 16'b01_0000_0011, "R4");
      // R7: ch0 again, ch1 must hold
      send_frame(10, 16'b00_0111_0001, "R7");
      // R5: broadcast
      send_frame(10, 16'b11_1010_0101, "R5");
      // R8: reserved address
      send_frame(10, 16'b10_0001_1111, "R8");
      // R9: short frames
      send_frame(9,  16'b0_0101_0101, "R9");
      send_frame(1,  16'b1, "R9");
      // R2: fourteen bits, only the last ten count
      send_frame(14, 16'b1011_01_1110_0001, "R2");
      // R11: short frame whose bits would form a valid ch0 write
      send_frame(7,  16'b000_1111, "R11");

      // R1: serial clock toggles with select high
      ser_dat = 1'b1;
      for (int k = 0; k < 12; k++) begin
         repeat (HALF_SCLK) @(negedge clk);
         ser_clk = ~ser_clk;
      end
      ser_clk = 1'b0;
      repeat (12) @(negedge clk);
      chk(wiper0_o == m_w0 && wiper1_o == m_w1, "R1", "wipers after idle clocks",
          {wiper1_o, wiper0_o}, {m_w1, m_w0});
      // R1: next frame must carry only its own bits
      send_frame(10, 16'b01_0000_0000, "R1");
      send_frame(12, 16'b11_11_1111_1111, "R2");

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule